// File: doc/BRIEF.md
# Speculative Three-Way Accumulator Update

This block applies one of three updates to a signed accumulator. The choice of update depends on the size of a signed sample. A large negative sample takes a fixed step off the accumulator. A large positive sample adds a fixed step to it. Any sample in between is scaled down by an arithmetic right shift and then added. The block does not resolve the choice first and compute afterwards. It computes all three candidate sums and both range comparisons in parallel, every cycle. Path predicates are formed from the two comparisons using AND, OR and NOT. These one-hot predicates drive an AND-OR multiplexer, which forwards the single correct candidate to the result register.

The sample and the accumulator each arrive with their own valid flag. An update is registered only in a cycle where both flags are high. In every other cycle the result register keeps its value and the output valid flag drops. The bounds, the step sizes, the shift amount and the data width are all parameters.

Top module: `spec_upd_top`

## Requirements
- R1: While reset is asserted (rst_n low), and after its release until the first valid update, `acc_out` is 0 and `out_vld` is 0.
- R2: When the sample, read as two's complement, is less than -8191, the registered result is the accumulator minus 100.
- R3: When the sample is greater than 8191, the registered result is the accumulator plus 255 (0xFF).
- R4: When the sample lies between -8191 and 8191 inclusive, the registered result is the accumulator plus the sample arithmetically shifted right by 5. The shift rounds toward minus infinity, so -1 gives -1 and -8191 gives -256.
- R5: All sums are 16-bit two's complement and wrap modulo 2^16 on overflow.
- R6: `out_vld` is high in the cycle after a clock edge at which both `smp_vld` and `acc_vld` were high, and low after any edge at which either was low.
- R7: At a clock edge where either input valid flag is low, `acc_out` keeps its previous value, whatever the data inputs carry.
- R8: For every sample value, exactly one of the three paths is selected. At the limits, -8192 and 8192 take the fixed steps, while -8191 and 8191 take the shifted path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp | input | 16 | Signed sample (two's complement) |
| smp_vld | input | 1 | Sample valid |
| acc | input | 16 | Current accumulator value (two's complement) |
| acc_vld | input | 1 | Accumulator valid |
| acc_out | output | 16 | Registered updated accumulator |
| out_vld | output | 1 | Result valid, one cycle after both input valid flags |

## Verification
The sample is driven on both sides of each comparison limit: -8192 against -8191, and 8191 against 8192. These pairs show whether each comparison is strict and whether a sample at a limit selects the right path. Both extreme values, -32768 and 32767, are also applied, to confirm that the comparisons treat the sample as signed. Small negative samples and the values 31 and 32 test the rounding direction of the arithmetic shift. Accumulators near the two ends of the range test wrap-around on all three paths. Runs with each valid flag dropped in turn, while the data inputs change, show that the output holds its value and that the valid output tracks the logical AND of the two input flags.

// File: rtl/spec_upd_pkg.sv
package spec_upd_pkg;

    // Path index inside the one-hot selection vector
    localparam int PATH_LOW  = 0;
    localparam int PATH_HIGH = 1;
    localparam int PATH_MID  = 2;
    localparam int NUM_PATHS = 3;

    typedef struct packed {
        logic [15:0] acc;
        logic        vld;
    } upd_state_t;

endpackage

// File: rtl/spec_upd_cond.sv
// Range comparisons on the sample, evaluated every cycle.
module spec_upd_cond #(
    parameter int DATA_W   = 16,
    parameter int LOW_LIM  = -8191,
    parameter int HIGH_LIM = 8191
) (
    input  logic [DATA_W-1:0] smp,
    output logic              below_lo,
    output logic              above_hi
);
    localparam logic signed [DATA_W-1:0] LO_S = LOW_LIM[DATA_W-1:0];
    localparam logic signed [DATA_W-1:0] HI_S = HIGH_LIM[DATA_W-1:0];

    logic signed [DATA_W-1:0] smp_s;

    always_comb begin
        smp_s    = $signed(smp);
        below_lo = (smp_s < LO_S);
        above_hi = (smp_s > HI_S);
    end
endmodule

// File: rtl/spec_upd_arms.sv
// All three candidate results computed in parallel, without regard to the branch.
module spec_upd_arms #(
    parameter int DATA_W    = 16,
    parameter int DEC_STEP  = 100,
    parameter int INC_STEP  = 255,
    parameter int SHIFT_AMT = 5,
    parameter int NPATH     = 3
) (
    input  logic [DATA_W-1:0]            smp,
    input  logic [DATA_W-1:0]            acc,
    output logic [NPATH-1:0][DATA_W-1:0] cand
);
    import spec_upd_pkg::*;

    localparam logic [DATA_W-1:0] DEC_V = DEC_STEP[DATA_W-1:0];
    localparam logic [DATA_W-1:0] INC_V = INC_STEP[DATA_W-1:0];

    logic signed [DATA_W-1:0] scaled;

    always_comb begin
        scaled          = $signed(smp) >>> SHIFT_AMT;
        cand            = '0;
        cand[PATH_LOW]  = acc - DEC_V;
        cand[PATH_HIGH] = acc + INC_V;
        cand[PATH_MID]  = acc + $unsigned(scaled);
    end
endmodule

// File: rtl/spec_upd_pred.sv
// Path predicates formed from the two branch conditions.
module spec_upd_pred #(
    parameter int NPATH = 3
) (
    input  logic             below_lo,
    input  logic             above_hi,
    output logic [NPATH-1:0] path_sel
);
    import spec_upd_pkg::*;

    logic p_first;   // first test taken
    logic p_else;    // first test not taken
    logic p_second;  // else-branch, second test taken
    logic p_last;    // else-branch, second test not taken

    always_comb begin
        p_first  = below_lo;
        p_else   = ~below_lo;
        p_second = p_else & above_hi;
        p_last   = p_else & ~above_hi;

        path_sel            = '0;
        path_sel[PATH_LOW]  = p_first;
        path_sel[PATH_HIGH] = p_second;
        path_sel[PATH_MID]  = p_last;
    end
endmodule

// File: rtl/spec_upd_mux.sv
// Fully decoded AND-OR multiplexer: one select bit per input.
module spec_upd_mux #(
    parameter int DATA_W = 16,
    parameter int NPATH  = 3
) (
    input  logic [NPATH-1:0][DATA_W-1:0] din,
    input  logic [NPATH-1:0]             sel,
    output logic [DATA_W-1:0]            dout
);
    logic [NPATH-1:0][DATA_W-1:0] gated;

    for (genvar g = 0; g < NPATH; g++) begin : g_gate
        assign gated[g] = din[g] & {DATA_W{sel[g]}};
    end

    always_comb begin
        dout = '0;
        for (int k = 0; k < NPATH; k++) begin
            dout = dout | gated[k];
        end
    end
endmodule

// File: rtl/spec_upd_top.sv
module spec_upd_top #(
    parameter int DATA_W    = 16,
    parameter int LOW_LIM   = -8191,
    parameter int HIGH_LIM  = 8191,
    parameter int DEC_STEP  = 100,
    parameter int INC_STEP  = 255,
    parameter int SHIFT_AMT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] acc,
    input  logic              acc_vld,
    output logic [DATA_W-1:0] acc_out,
    output logic              out_vld
);
    import spec_upd_pkg::*;

    localparam int NPATH = NUM_PATHS;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              vld;
    } state_t;

    logic                         below_lo;
    logic                         above_hi;
    logic [NPATH-1:0]             path_sel;
    logic [NPATH-1:0][DATA_W-1:0] cand;
    logic [DATA_W-1:0]            picked;
    logic                         take;

    state_t st_d, st_q;

    spec_upd_cond #(
        .DATA_W  (DATA_W),
        .LOW_LIM (LOW_LIM),
        .HIGH_LIM(HIGH_LIM)
    ) cond_i (
        .smp     (smp),
        .below_lo(below_lo),
        .above_hi(above_hi)
    );

    spec_upd_arms #(
        .DATA_W   (DATA_W),
        .DEC_STEP (DEC_STEP),
        .INC_STEP (INC_STEP),
        .SHIFT_AMT(SHIFT_AMT),
        .NPATH    (NPATH)
    ) arms_i (
        .smp (smp),
        .acc (acc),
        .cand(cand)
    );

    spec_upd_pred #(
        .NPATH(NPATH)
    ) pred_i (
        .below_lo(below_lo),
        .above_hi(above_hi),
        .path_sel(path_sel)
    );

    spec_upd_mux #(
        .DATA_W(DATA_W),
        .NPATH (NPATH)
    ) mux_i (
        .din (cand),
        .sel (path_sel),
        .dout(picked)
    );

    always_comb begin
        take   = smp_vld & acc_vld;
        st_d   = st_q;
        st_d.vld = take;
        if (take) begin
            st_d.acc = picked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out = st_q.acc;
    assign out_vld = st_q.vld;

endmodule

// File: rtl/spec_upd_chk.sv
module spec_upd_chk #(
    parameter int DATA_W   = 16,
    parameter int LOW_LIM  = -8191,
    parameter int HIGH_LIM = 8191,
    parameter int DEC_STEP = 100,
    parameter int INC_STEP = 255
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] smp,
    input logic              smp_vld,
    input logic [DATA_W-1:0] acc,
    input logic              acc_vld,
    input logic [DATA_W-1:0] acc_out,
    input logic              out_vld,
    input logic [2:0]        path_sel
);
    localparam logic signed [DATA_W-1:0] LO_S = LOW_LIM[DATA_W-1:0];
    localparam logic signed [DATA_W-1:0] HI_S = HIGH_LIM[DATA_W-1:0];
    localparam logic [DATA_W-1:0] DEC_V = DEC_STEP[DATA_W-1:0];
    localparam logic [DATA_W-1:0] INC_V = INC_STEP[DATA_W-1:0];

    // R8
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(path_sel) == 1);

    // R6
    vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && acc_vld) |=> out_vld);

    // R6
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_vld && acc_vld) |=> !out_vld);

    // R7
    hold_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_vld && acc_vld) |=> $stable(acc_out));

    // R2
    low_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && acc_vld && ($signed(smp) < LO_S))
        |=> acc_out == $past(acc) - DEC_V);

    // R3
    high_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && acc_vld && ($signed(smp) > HI_S))
        |=> acc_out == $past(acc) + INC_V);
endmodule

bind spec_upd_top spec_upd_chk #(
    .DATA_W  (DATA_W),
    .LOW_LIM (LOW_LIM),
    .HIGH_LIM(HIGH_LIM),
    .DEC_STEP(DEC_STEP),
    .INC_STEP(INC_STEP)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp     (smp),
    .smp_vld (smp_vld),
    .acc     (acc),
    .acc_vld (acc_vld),
    .acc_out (acc_out),
    .out_vld (out_vld),
    .path_sel(path_sel)
);

// File: tb/spec_upd_top_tb_top.sv
module spec_upd_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] smp = '0;
    logic        smp_vld = 1'b0;
    logic [15:0] acc = '0;
    logic        acc_vld = 1'b0;
    logic [15:0] acc_out;
    logic        out_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    spec_upd_top dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp    (smp),
        .smp_vld(smp_vld),
        .acc    (acc),
        .acc_vld(acc_vld),
        .acc_out(acc_out),
        .out_vld(out_vld)
    );

    // {requirement tag, sample, accumulator, expected result}
    localparam int NV = 14;
    localparam logic [55:0] VEC [NV] = '{
        {8'd2, 16'hE000, 16'h03E8, 16'h0384},  // -8192: fixed decrement
        {8'd8, 16'hE001, 16'h03E8, 16'h02E8},  // -8191: shifted path, -256
        {8'd8, 16'h1FFF, 16'h03E8, 16'h04E7},  // 8191: shifted path, +255
        {8'd3, 16'h2000, 16'h03E8, 16'h04E7},  // 8192: fixed increment
        {8'd2, 16'h8000, 16'h0000, 16'hFF9C},  // most negative sample
        {8'd3, 16'h7FFF, 16'h0000, 16'h00FF},  // most positive sample
        {8'd4, 16'h0000, 16'h01F4, 16'h01F4},  // zero
        {8'd4, 16'hFFFF, 16'h01F4, 16'h01F3},  // -1 shifts to -1
        {8'd4, 16'h001F, 16'h01F4, 16'h01F4},  // 31 shifts to 0
        {8'd4, 16'h0020, 16'h01F4, 16'h01F5},  // 32 shifts to 1
        {8'd4, 16'hFFDF, 16'h01F4, 16'h01F2},  // -33 shifts to -2
        {8'd5, 16'h2328, 16'h7FFF, 16'h80FE},  // increment wraps
        {8'd5, 16'hDCD8, 16'h8000, 16'h7F9C},  // decrement wraps
        {8'd5, 16'h1388, 16'h7FF8, 16'h8094}   // shifted add wraps
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive at negedge, registered at next posedge, sampled at following negedge
    task automatic apply(input logic [15:0] s, input logic sv,
                         input logic [15:0] a, input logic av);
        @(negedge clk);
        smp = s; smp_vld = sv; acc = a; acc_vld = av;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 acc_out in reset", acc_out, 16'h0000);
        check("R1 out_vld in reset", {15'b0, out_vld}, 16'h0001 & 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 acc_out after release", acc_out, 16'h0000);
        check("R1 out_vld after release", {15'b0, out_vld}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][47:32], 1'b1, VEC[i][31:16], 1'b1);
            case (VEC[i][55:48])
                8'd2: check("R2 low step", acc_out, VEC[i][15:0]);
                8'd3: check("R3 high step", acc_out, VEC[i][15:0]);
                8'd4: check("R4 shifted add", acc_out, VEC[i][15:0]);
                8'd5: check("R5 wrap", acc_out, VEC[i][15:0]);
                default: check("R8 limit path", acc_out, VEC[i][15:0]);
            endcase
            check("R6 valid after update", {15'b0, out_vld}, 16'h0001);
        end

        // R7 / R6: sample valid low, data changes
        held = acc_out;
        apply(16'h2000, 1'b0, 16'h1234, 1'b1);
        check("R7 hold with sample invalid", acc_out, held);
        check("R6 valid low with sample invalid", {15'b0, out_vld}, 16'h0000);
        // R7 / R6: accumulator valid low
        apply(16'hE000, 1'b1, 16'h4321, 1'b0);
        check("R7 hold with acc invalid", acc_out, held);
        check("R6 valid low with acc invalid", {15'b0, out_vld}, 16'h0000);
        // R6: both valid again
        apply(16'h0040, 1'b1, 16'h0010, 1'b1);
        check("R4 after idle", acc_out, 16'h0012);
        check("R6 valid back", {15'b0, out_vld}, 16'h0001);

        // R1: reset mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        smp_vld = 1'b0; acc_vld = 1'b0;
        @(negedge clk);
        check("R1 acc_out re-reset", acc_out, 16'h0000);
        check("R1 out_vld re-reset", {15'b0, out_vld}, 16'h0000);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule